// File: doc/BRIEF.md
# Banked Scratchpad Conflict Serializer

This block takes one read request from sixteen lanes. Each lane gives an active bit and a word address. The scratchpad behind the lanes is split into sixteen banks, each one word (32 bits) wide. The bank that holds a word is fixed by the low address bits. Each bank can deliver one word per cycle.

When the active lanes hit distinct banks, or share words, the request completes in a single cycle. When lanes hit the same bank at different words, the block serializes them into rounds. In each round a bank serves one word, and that word goes to every lane that asked for it. The lowest-numbered lane that is still waiting in the bank decides which word is served first.

The block raises a stall signal while rounds are still being issued. Each lane receives its word with a valid strobe one cycle after the round that served it. A simple write port fills the storage.

Top module: `scrpad_bank_serializer`

## Requirements
- R1: A word address maps to bank `addr[3:0]` (address modulo 16). Lanes whose addresses differ only in the upper bits but have distinct low nibbles do not conflict.
- R2: A request whose active lanes all target different banks completes in exactly one round.
- R3: When n active lanes target one bank at n different words, that bank needs n rounds.
- R4: Any number of lanes reading the same word are served together in one round, and that word counts as a single access in its bank.
- R5: The number of rounds for a request equals the maximum, over all banks, of the number of distinct words requested in that bank.
- R6: Within a bank, words are served in order of their lowest requesting lane number. The word of the lowest-numbered waiting lane goes first, and it goes to every lane that asked for it.
- R7: Each active lane gets exactly one `rspValid` pulse, one cycle after its round, with `rspData` equal to the stored word. Inactive lanes get none.
- R8: A request is taken when `reqValid` is high and `busy` is low. From the next cycle, `busy` stays high for exactly as many cycles as there are rounds. A `reqValid` pulse that arrives while `busy` is high is ignored.
- R9: A request with no active lanes leaves `busy` low and produces no responses.
- R10: After reset, `busy` and `rspValid` are all zero.
- R11: When `wrEn` is high, `wrData` is stored at `wrAddr` on the clock edge. Later reads of that word return the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe for the storage array |
| wrAddr | input | 8 | Word address to write |
| wrData | input | 32 | Word to write |
| reqValid | input | 1 | Offers a new lane request |
| laneActive | input | 16 | Per-lane active bits |
| laneAddr | input | 128 | Per-lane word addresses; lane i sits at bits [8i+7:8i] |
| busy | output | 1 | High while rounds remain to issue (stall) |
| rspValid | output | 16 | Per-lane read data valid strobes |
| rspData | output | 512 | Per-lane read words; lane i sits at bits [32i+31:32i] |

## Verification
The assertions check the handshake timing on every cycle:
- a response never appears unless the block was busy the cycle before;
- every busy cycle is followed by at least one response;
- an accepted request with active lanes raises `busy`, and an empty one does not;
- the cycle in which `busy` drops always carries a response.

The bench scenarios cover what a per-cycle property cannot see. These are the exact round count for a pattern, the round each lane lands in given the lowest-lane ordering, broadcast merging, the returned data against a model of the storage, and a mid-request `reqValid` being ignored.

// File: rtl/scrpad_pkg.sv
package scrpad_pkg;
  localparam int LANES  = 16;
  localparam int BANKS  = 16;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam int BANK_W = $clog2(BANKS);
  localparam int DEPTH  = 1 << ADDR_W;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] word_t;

  // strobes from control to datapath
  typedef struct packed {
    logic             load;
    logic [LANES-1:0] serve;
  } ctrl_t;
endpackage

// File: rtl/scrpad_ctrl.sv
module scrpad_ctrl
  import scrpad_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [LANES-1:0] laneActive,
  input  addr_t            heldAddr [LANES],
  output ctrl_t            ctrlS,
  output logic             busy
);
  logic [LANES-1:0] pending;
  logic [LANES-1:0] serveMask;
  addr_t            winWord [BANKS];
  logic [BANKS-1:0] bankHit;

  assign busy = |pending;

  // per bank: word of the lowest-numbered pending lane
  always_comb begin
    for (int b = 0; b < BANKS; b++) begin
      bankHit[b] = 1'b0;
      winWord[b] = '0;
      for (int l = 0; l < LANES; l++) begin
        if (!bankHit[b] && pending[l] && heldAddr[l][BANK_W-1:0] == BANK_W'(b)) begin
          bankHit[b] = 1'b1;
          winWord[b] = heldAddr[l];
        end
      end
    end
  end

  // a lane is served when its word is the winner of its bank
  genvar gl;
  generate
    for (gl = 0; gl < LANES; gl++) begin : g_serve
      assign serveMask[gl] = pending[gl] &&
                             (heldAddr[gl] == winWord[heldAddr[gl][BANK_W-1:0]]);
    end
  endgenerate

  assign ctrlS.load  = reqValid && !busy;
  assign ctrlS.serve = serveMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            pending <= '0;
    else if (ctrlS.load)  pending <= laneActive;
    else                  pending <= pending & ~serveMask;
  end
endmodule

// File: rtl/scrpad_dpath.sv
module scrpad_dpath
  import scrpad_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrl_t                   ctrlS,
  input  logic                    wrEn,
  input  addr_t                   wrAddr,
  input  word_t                   wrData,
  input  logic [LANES*ADDR_W-1:0] laneAddrIn,
  output addr_t                   heldAddr [LANES],
  output logic [LANES-1:0]        rspValid,
  output logic [LANES*DATA_W-1:0] rspData
);
  word_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrAddr] <= wrData;
  end

  genvar gl;
  generate
    for (gl = 0; gl < LANES; gl++) begin : g_lane
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)           heldAddr[gl] <= '0;
        else if (ctrlS.load) heldAddr[gl] <= laneAddrIn[gl*ADDR_W +: ADDR_W];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= '0;
      rspData  <= '0;
    end else begin
      rspValid <= ctrlS.serve;
      for (int l = 0; l < LANES; l++) begin
        if (ctrlS.serve[l]) rspData[l*DATA_W +: DATA_W] <= mem[heldAddr[l]];
      end
    end
  end
endmodule

// File: rtl/scrpad_bank_serializer.sv
module scrpad_bank_serializer
  import scrpad_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wrEn,
  input  logic [ADDR_W-1:0]       wrAddr,
  input  logic [DATA_W-1:0]       wrData,
  input  logic                    reqValid,
  input  logic [LANES-1:0]        laneActive,
  input  logic [LANES*ADDR_W-1:0] laneAddr,
  output logic                    busy,
  output logic [LANES-1:0]        rspValid,
  output logic [LANES*DATA_W-1:0] rspData
);
  ctrl_t ctrlS;
  addr_t heldAddr [LANES];

  scrpad_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .laneActive (laneActive),
    .heldAddr   (heldAddr),
    .ctrlS      (ctrlS),
    .busy       (busy)
  );

  scrpad_dpath u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .ctrlS      (ctrlS),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .laneAddrIn (laneAddr),
    .heldAddr   (heldAddr),
    .rspValid   (rspValid),
    .rspData    (rspData)
  );
endmodule

// File: rtl/scrpad_chk.sv
module scrpad_chk
  import scrpad_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic [LANES-1:0] laneActive,
  input logic             busy,
  input logic [LANES-1:0] rspValid
);
  // R7
  rsp_after_round_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid != '0) |-> $past(busy));

  // R8
  busy_progress_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (rspValid != '0));

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy && laneActive != '0) |=> busy);

  // R9
  empty_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy && laneActive == '0) |=> !busy);

  // R5
  last_round_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (rspValid != '0));
endmodule

bind scrpad_bank_serializer scrpad_chk chk_i (.*);

// File: tb/scrpad_bank_serializer_tb.sv
module scrpad_bank_serializer_tb_top;
  import scrpad_pkg::*;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                    rstN;
  logic                    wrEn;
  logic [ADDR_W-1:0]       wrAddr;
  logic [DATA_W-1:0]       wrData;
  logic                    reqValid;
  logic [LANES-1:0]        laneActive;
  logic [LANES*ADDR_W-1:0] laneAddr;
  logic                    busy;
  logic [LANES-1:0]        rspValid;
  logic [LANES*DATA_W-1:0] rspData;

  scrpad_bank_serializer dut_i (.*);

  int checks = 0;
  int errors = 0;
  word_t refMem [DEPTH];
  addr_t tAddr [LANES];
  logic [LANES-1:0] tAct;

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // round (0-based) in which lane l is served per R6
  function automatic int rankOf(int l);
    int fl, r;
    fl = l;
    for (int f = LANES - 1; f >= 0; f--)
      if (tAct[f] && tAddr[f] == tAddr[l]) fl = f;
    r = 0;
    for (int j = 0; j < fl; j++) begin
      bit first;
      first = 1'b1;
      for (int i = 0; i < j; i++)
        if (tAct[i] && tAddr[i] == tAddr[j]) first = 1'b0;
      if (tAct[j] && first && tAddr[j][BANK_W-1:0] == tAddr[l][BANK_W-1:0]) r++;
    end
    return r;
  endfunction

  // R5 reference: max over banks of distinct words
  function automatic int expRounds();
    int m;
    m = 0;
    for (int l = 0; l < LANES; l++)
      if (tAct[l] && rankOf(l) + 1 > m) m = rankOf(l) + 1;
    return m;
  endfunction

  task automatic writeWord(addr_t a, word_t d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    refMem[a] = d;
  endtask

  task automatic runReq(string tag, bit intrude);
    int gotRound [LANES];
    word_t gotData [LANES];
    int busyCnt, exp, firstBusy;
    exp = expRounds();
    for (int l = 0; l < LANES; l++) begin gotRound[l] = -1; gotData[l] = '0; end
    @(negedge clk);
    reqValid = 1'b1;
    laneActive = tAct;
    for (int l = 0; l < LANES; l++) laneAddr[l*ADDR_W +: ADDR_W] = tAddr[l];
    busyCnt = 0;
    firstBusy = 0;
    for (int s = 0; s < LANES + 3; s++) begin
      @(negedge clk);
      if (s == 0) begin
        if (intrude) begin
          laneActive = ~tAct;
          laneAddr = {4{$urandom()}};
        end else reqValid = 1'b0;
        firstBusy = int'(busy);
      end
      if (s == 1) reqValid = 1'b0;
      if (busy) busyCnt++;
      for (int l = 0; l < LANES; l++)
        if (rspValid[l]) begin
          gotRound[l] = (gotRound[l] == -1) ? s : -2;
          gotData[l] = rspData[l*DATA_W +: DATA_W];
        end
    end
    check({tag, " R5 round count"}, busyCnt, exp);
    check({tag, " R8 busy after accept"}, firstBusy, int'(exp > 0));
    for (int l = 0; l < LANES; l++) begin
      if (tAct[l]) begin
        check({tag, " R6 lane round"}, gotRound[l], rankOf(l) + 1);
        check({tag, " R7 lane data"}, int'(gotData[l] == refMem[tAddr[l]]), 1);
      end else
        check({tag, " R7 inactive lane"}, gotRound[l], -1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got 0 expected 1 (run ended)");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    rstN = 1'b0; wrEn = 1'b0; wrAddr = '0; wrData = '0;
    reqValid = 1'b0; laneActive = '0; laneAddr = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10
    check("R10 busy after reset", int'(busy), 0);
    check("R10 rspValid after reset", int'(rspValid), 0);

    // R11 fill storage
    for (int a = 0; a < DEPTH; a++) writeWord(addr_t'(a), $urandom());

    // R1: distinct low nibbles, mixed upper bits
    tAct = '1;
    for (int l = 0; l < LANES; l++) tAddr[l] = addr_t'((l * 16 * 5 + l) % DEPTH);
    for (int l = 0; l < LANES; l++) tAddr[l] = {tAddr[l][ADDR_W-1:BANK_W], BANK_W'(l)};
    runReq("R1 R2 distinct banks", 1'b1);
    check("R1 R2 one round", expRounds(), 1);

    // R2 stride 1
    for (int l = 0; l < LANES; l++) tAddr[l] = addr_t'(l + 3);
    runReq("R2 stride1", 1'b0);

    // R3 stride 2 and stride 8, stride 16
    for (int l = 0; l < LANES; l++) tAddr[l] = addr_t'(2 * l);
    runReq("R3 stride2", 1'b1);
    check("R3 stride2 ref", expRounds(), 2);
    for (int l = 0; l < LANES; l++) tAddr[l] = addr_t'(8 * l);
    runReq("R3 stride8", 1'b0);
    check("R3 stride8 ref", expRounds(), 8);
    for (int l = 0; l < LANES; l++) tAddr[l] = addr_t'(16 * l + 5);
    runReq("R3 stride16", 1'b1);

    // R4 broadcast
    for (int l = 0; l < LANES; l++) tAddr[l] = 8'd77;
    runReq("R4 broadcast", 1'b1);
    check("R4 broadcast ref", expRounds(), 1);

    // R6 ordering: lane 0 word appears again later
    for (int l = 0; l < LANES; l++) tAddr[l] = (l % 3 == 0) ? 8'h10 : ((l % 3 == 1) ? 8'h20 : 8'h30);
    runReq("R6 R4 order", 1'b0);

    // R9 empty request
    tAct = '0;
    runReq("R9 empty", 1'b0);

    // R11 rewrite then read
    writeWord(8'h20, 32'hCAFE_0020);
    writeWord(8'h31, 32'h1234_5678);
    tAct = 16'h0003;
    tAddr[0] = 8'h20; tAddr[1] = 8'h31;
    runReq("R11 rewrite", 1'b0);

    for (int it = 0; it < 80; it++) begin
      int mode, base, stride;
      addr_t pool [3];
      mode = int'($urandom() % 5);
      base = int'($urandom() % DEPTH);
      stride = int'($urandom() % 17);
      for (int p = 0; p < 3; p++) pool[p] = addr_t'($urandom());
      tAct = ($urandom() % 3 == 0) ? '1 : LANES'($urandom());
      for (int l = 0; l < LANES; l++) begin
        case (mode)
          0: tAddr[l] = addr_t'($urandom());
          1: tAddr[l] = addr_t'(base + l * stride);
          2: tAddr[l] = pool[$urandom() % 3];
          3: tAddr[l] = addr_t'(base);
          default: tAddr[l] = {addr_t'($urandom())} & 8'hF3;
        endcase
      end
      if (it % 10 == 0) writeWord(tAddr[0], $urandom());
      runReq("R5 random", (tAct != '0) && ($urandom() % 2 == 0));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule